// File: doc/BRIEF.md
# Issue Select with Functional-Unit Pool

This block sits between the per-class ready lists of an out-of-order core's instruction queue and its execution units. Each cycle it looks at the head of every operation-class list: sequence number, squashed flag and memory flag. It picks the oldest heads that can get a unit, up to a configured issue width. It tells each list whether its head was consumed. Operations of latency one go to execute in the cycle they are picked. Longer operations are timed inside the block, which strobes their completion on a per-class port.

Each class has three parameters: a unit count, a latency and a pipelined flag. A pipelined class can take a new operation every cycle. A non-pipelined class holds its unit until the operation on it completes. A class with zero units is unsupported. It issues as a latency-one operation and takes no unit. The default build has four classes:
- class 0: latency 1, one unit
- class 1: latency 3, pipelined, one unit
- class 2: latency 4, not pipelined, one unit
- class 3: zero units

The default issue width is 2.

Top module: `iss_select`

## Requirements
- R1: At most ISSUE_W heads are granted per cycle. A grant goes to the valid, unsquashed heads that have a free unit, taken in ascending order of sequence number (an unsigned compare with no wraparound). Equal sequence numbers go to the lower class index first.
- R2: A valid squashed head is popped (o_pop bit set) without a grant, and it does not use up an issue slot.
- R3: A head whose class has no free unit gets neither grant nor pop, and its slot passes to the next-oldest eligible class.
- R4: A granted head of effective latency 1 raises its o_exec bit in the same cycle. A pipelined class with one unit can be granted in consecutive cycles.
- R5: A multi-cycle operation granted in cycle t raises o_cmp_valid for its class in cycle t+LAT-1, with o_cmp_seq carrying its sequence number. The port is low otherwise.
- R6: A non-pipelined unit is busy from its grant until its completion strobe. The same unit can be granted again in cycle t+LAT at the earliest.
- R7: A grant for a head with the memory flag clear raises o_release (the queue entry is freed). A grant for a head with the memory flag set raises o_memdep instead, and o_release stays low.
- R8: A class with zero units is granted as a latency-1 operation: o_exec is set and no completion strobe ever follows.
- R9: o_wb_pending equals the number of multi-cycle operations that have been granted and whose completion strobe has not yet passed.
- R10: Operations of different classes that complete in the same cycle are each reported on their own class port in that cycle.
- R11: While reset is active, and in the first cycle after it, there are no completion strobes and o_wb_pending is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| i_hd_valid | input | NCLS | Ready-list head present, one bit per class |
| i_hd_seq | input | NCLS x SEQW | Head sequence number per class |
| i_hd_squash | input | NCLS | Head has been squashed |
| i_hd_mem | input | NCLS | Head is a memory operation |
| o_pop | output | NCLS | Head consumed (granted or discarded) |
| o_grant | output | NCLS | Head issued this cycle |
| o_exec | output | NCLS | Granted head goes to execute now (latency 1) |
| o_release | output | NCLS | Queue entry freed by a non-memory grant |
| o_memdep | output | NCLS | Memory grant reported to dependence tracking |
| o_cmp_valid | output | NCLS | Multi-cycle completion strobe per class |
| o_cmp_seq | output | NCLS x SEQW | Sequence number of the completing operation |
| o_wb_pending | output | PW | Count of outstanding multi-cycle operations |

## Verification
The bench aims at the points where selection and unit state interact. It presents more eligible heads than the issue width, in scrambled age order. A selector that scanned by class index instead of by age would grant the wrong pair. It puts a squashed head in front of two live ones: a design that spent a slot on it would starve the third class. It holds a head on the busy non-pipelined unit through the whole busy window. A unit freed one cycle early or late shows up as a grant in the wrong cycle. It also lines up completions from two classes in one cycle and counts back-to-back pipelined issues in the pending count. Off-by-one latency timing or a single shared completion port would be caught there.

// File: rtl/iss_pkg.sv
package iss_pkg;
  // Upper bound on any class latency; sizes the pending counter.
  localparam int unsigned MAX_LAT = 16;

  // Latency actually applied: zero-unit classes behave as single-cycle.
  function automatic int unsigned eff_lat(input int unsigned units, input int unsigned lat);
    return (units == 0 || lat < 2) ? 1 : lat;
  endfunction
endpackage

// File: rtl/iss_age_rank.sv
module iss_age_rank #(
  parameter int unsigned NCLS    = 4,
  parameter int unsigned SEQW    = 8,
  parameter int unsigned ISSUE_W = 2
) (
  input  logic [NCLS-1:0]           i_elig,
  input  logic [NCLS-1:0][SEQW-1:0] i_seq,
  output logic [NCLS-1:0]           o_sel
);
  // A candidate wins when fewer than ISSUE_W eligible candidates are older.
  always_comb begin
    for (int i = 0; i < NCLS; i++) begin
      int unsigned older_cnt;
      older_cnt = 0;
      for (int j = 0; j < NCLS; j++) begin
        if (j != i && i_elig[j] &&
            ((i_seq[j] < i_seq[i]) || (i_seq[j] == i_seq[i] && j < i)))
          older_cnt = older_cnt + 1;
      end
      o_sel[i] = i_elig[i] && (older_cnt < ISSUE_W);
    end
  end
endmodule

// File: rtl/iss_fu_track.sv
module iss_fu_track #(
  parameter int unsigned SEQW  = 8,
  parameter int unsigned UNITS = 1,
  parameter int unsigned LAT   = 1,
  parameter bit          PIPE  = 1'b1,
  parameter int unsigned PW    = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            i_issue,
  input  logic [SEQW-1:0] i_seq,
  output logic            o_avail,
  output logic            o_cmp_valid,
  output logic [SEQW-1:0] o_cmp_seq,
  output logic [PW-1:0]   o_inflight
);
  localparam int unsigned ELAT = iss_pkg::eff_lat(UNITS, LAT);

  generate
    if (ELAT == 1) begin : g_single
      // Unit frees itself at the next edge: always available at cycle start.
      assign o_avail     = 1'b1;
      assign o_cmp_valid = 1'b0;
      assign o_cmp_seq   = '0;
      assign o_inflight  = '0;
    end else begin : g_multi
      localparam int unsigned DEPTH = ELAT - 1;
      logic [DEPTH-1:0]           stg_v;
      logic [DEPTH-1:0][SEQW-1:0] stg_s;

      always_ff @(posedge clk) begin
        if (rst) begin
          stg_v <= '0;
        end else begin
          stg_v[0] <= i_issue;
          for (int k = 1; k < DEPTH; k++) stg_v[k] <= stg_v[k-1];
        end
        stg_s[0] <= i_seq;
        for (int k = 1; k < DEPTH; k++) stg_s[k] <= stg_s[k-1];
      end

      logic [PW-1:0] busy_cnt;
      always_comb begin
        busy_cnt = '0;
        for (int k = 0; k < DEPTH; k++) busy_cnt = busy_cnt + PW'(stg_v[k]);
      end

      if (PIPE) begin : g_pipe
        assign o_avail = 1'b1;
      end else begin : g_hold
        assign o_avail = (busy_cnt < PW'(UNITS));
      end

      assign o_cmp_valid = stg_v[DEPTH-1];
      assign o_cmp_seq   = stg_s[DEPTH-1];
      assign o_inflight  = busy_cnt;
    end
  endgenerate
endmodule

// File: rtl/iss_select.sv
module iss_select #(
  parameter int unsigned NCLS              = 4,
  parameter int unsigned SEQW              = 8,
  parameter int unsigned ISSUE_W           = 2,
  parameter int unsigned CLS_UNITS [NCLS]  = '{1, 1, 1, 0},
  parameter int unsigned CLS_LAT   [NCLS]  = '{1, 3, 4, 1},
  parameter bit          CLS_PIPE  [NCLS]  = '{1'b1, 1'b1, 1'b0, 1'b1},
  parameter int unsigned PW                = $clog2(NCLS * iss_pkg::MAX_LAT + 1)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NCLS-1:0]           i_hd_valid,
  input  logic [NCLS-1:0][SEQW-1:0] i_hd_seq,
  input  logic [NCLS-1:0]           i_hd_squash,
  input  logic [NCLS-1:0]           i_hd_mem,
  output logic [NCLS-1:0]           o_pop,
  output logic [NCLS-1:0]           o_grant,
  output logic [NCLS-1:0]           o_exec,
  output logic [NCLS-1:0]           o_release,
  output logic [NCLS-1:0]           o_memdep,
  output logic [NCLS-1:0]           o_cmp_valid,
  output logic [NCLS-1:0][SEQW-1:0] o_cmp_seq,
  output logic [PW-1:0]             o_wb_pending
);
  logic [NCLS-1:0]         avail;
  logic [NCLS-1:0]         elig;
  logic [NCLS-1:0]         single;
  logic [NCLS-1:0][PW-1:0] inflight;

  assign elig = i_hd_valid & ~i_hd_squash & avail;

  iss_age_rank #(.NCLS(NCLS), .SEQW(SEQW), .ISSUE_W(ISSUE_W)) u_rank (
    .i_elig (elig),
    .i_seq  (i_hd_seq),
    .o_sel  (o_grant)
  );

  for (genvar c = 0; c < NCLS; c++) begin : g_cls
    assign single[c] = (iss_pkg::eff_lat(CLS_UNITS[c], CLS_LAT[c]) == 1);

    iss_fu_track #(
      .SEQW(SEQW), .UNITS(CLS_UNITS[c]), .LAT(CLS_LAT[c]),
      .PIPE(CLS_PIPE[c]), .PW(PW)
    ) u_fu (
      .clk         (clk),
      .rst         (rst),
      .i_issue     (o_grant[c]),
      .i_seq       (i_hd_seq[c]),
      .o_avail     (avail[c]),
      .o_cmp_valid (o_cmp_valid[c]),
      .o_cmp_seq   (o_cmp_seq[c]),
      .o_inflight  (inflight[c])
    );
  end

  assign o_pop     = o_grant | (i_hd_valid & i_hd_squash);
  assign o_exec    = o_grant & single;
  assign o_release = o_grant & ~i_hd_mem;
  assign o_memdep  = o_grant & i_hd_mem;

  always_comb begin
    o_wb_pending = '0;
    for (int c = 0; c < NCLS; c++) o_wb_pending = o_wb_pending + inflight[c];
  end
endmodule

// File: rtl/iss_select_chk.sv
module iss_select_chk #(
  parameter int unsigned NCLS             = 4,
  parameter int unsigned ISSUE_W          = 2,
  parameter int unsigned CLS_UNITS [NCLS] = '{1, 1, 1, 0},
  parameter int unsigned CLS_LAT   [NCLS] = '{1, 3, 4, 1},
  parameter bit          CLS_PIPE  [NCLS] = '{1'b1, 1'b1, 1'b0, 1'b1}
) (
  input logic            clk,
  input logic            rst,
  input logic [NCLS-1:0] i_hd_valid,
  input logic [NCLS-1:0] i_hd_squash,
  input logic [NCLS-1:0] i_hd_mem,
  input logic [NCLS-1:0] o_grant,
  input logic [NCLS-1:0] o_pop,
  input logic [NCLS-1:0] o_exec,
  input logic [NCLS-1:0] o_release,
  input logic [NCLS-1:0] o_memdep,
  input logic [NCLS-1:0] o_cmp_valid
);
  p_width_r1: assert property (@(posedge clk) disable iff (rst)
    $countones(o_grant) <= ISSUE_W);

  p_grant_popped_r1: assert property (@(posedge clk) disable iff (rst)
    ((o_grant & ~o_pop) == '0) && ((o_pop & ~i_hd_valid) == '0));

  p_no_squash_grant_r2: assert property (@(posedge clk) disable iff (rst)
    (o_grant & i_hd_squash) == '0);

  p_exec_granted_r4: assert property (@(posedge clk) disable iff (rst)
    (o_exec & ~o_grant) == '0);

  p_mem_split_r7: assert property (@(posedge clk) disable iff (rst)
    ((o_release & i_hd_mem) == '0) && ((o_memdep & ~i_hd_mem) == '0));

  for (genvar c = 0; c < NCLS; c++) begin : g_c
    if (iss_pkg::eff_lat(CLS_UNITS[c], CLS_LAT[c]) == 1) begin : g_one
      p_no_cmp_single_r8: assert property (@(posedge clk) disable iff (rst)
        !o_cmp_valid[c]);
    end else if (!CLS_PIPE[c] && CLS_UNITS[c] == 1) begin : g_hold
      p_busy_after_grant_r6: assert property (@(posedge clk) disable iff (rst)
        o_grant[c] |=> !o_grant[c]);
    end
  end
endmodule

bind iss_select iss_select_chk #(
  .NCLS(NCLS), .ISSUE_W(ISSUE_W), .CLS_UNITS(CLS_UNITS),
  .CLS_LAT(CLS_LAT), .CLS_PIPE(CLS_PIPE)
) u_chk (
  .clk(clk), .rst(rst), .i_hd_valid(i_hd_valid), .i_hd_squash(i_hd_squash),
  .i_hd_mem(i_hd_mem), .o_grant(o_grant), .o_pop(o_pop), .o_exec(o_exec),
  .o_release(o_release), .o_memdep(o_memdep), .o_cmp_valid(o_cmp_valid)
);

// File: tb/iss_select_bench.sv
module iss_select_bench;
  localparam int NCLS = 4;
  localparam int SEQW = 8;
  localparam int PW   = $clog2(NCLS * iss_pkg::MAX_LAT + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NCLS-1:0]           hd_valid, hd_squash, hd_mem;
  logic [NCLS-1:0][SEQW-1:0] hd_seq;
  logic [NCLS-1:0]           pop, grant, exec_o, rel, memdep, cmp_v;
  logic [NCLS-1:0][SEQW-1:0] cmp_seq;
  logic [PW-1:0]             pending;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  iss_select u_iss_select (
    .clk(clk), .rst(rst), .i_hd_valid(hd_valid), .i_hd_seq(hd_seq),
    .i_hd_squash(hd_squash), .i_hd_mem(hd_mem), .o_pop(pop), .o_grant(grant),
    .o_exec(exec_o), .o_release(rel), .o_memdep(memdep), .o_cmp_valid(cmp_v),
    .o_cmp_seq(cmp_seq), .o_wb_pending(pending)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clr();
    hd_valid = '0; hd_squash = '0; hd_mem = '0; hd_seq = '0;
  endtask

  task automatic put(input int c, input int seq, input bit sq, input bit mem);
    hd_valid[c] = 1'b1; hd_seq[c] = SEQW'(seq); hd_squash[c] = sq; hd_mem[c] = mem;
  endtask

  task automatic next_cycle();
    @(posedge clk); #2;
  endtask

  task automatic settle();
    #8;
  endtask

  task automatic do_reset();
    rst = 1'b1; clr();
    repeat (2) @(posedge clk);
    #2 rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    settle();
    chk("R11", "cmp_valid", int'(cmp_v), 0);
    chk("R11", "pending", int'(pending), 0);
    chk("R11", "grant idle", int'(grant), 0);
  endtask

  task automatic t_width_age();
    do_reset();
    next_cycle();
    put(0, 10, 0, 0); put(1, 5, 0, 0); put(2, 7, 0, 0); put(3, 3, 0, 0);
    settle();
    chk("R1", "grant oldest two", int'(grant), 4'b1010);
    chk("R1", "pop", int'(pop), 4'b1010);
    chk("R8", "exec unsupported class", int'(exec_o), 4'b1000);
    chk("R7", "release", int'(rel), 4'b1010);
    next_cycle(); clr(); settle();
    chk("R5", "no early cmp", int'(cmp_v), 0);
    chk("R9", "pending one", int'(pending), 1);
    next_cycle(); settle();
    chk("R5", "cmp class1", int'(cmp_v), 4'b0010);
    chk("R5", "cmp seq", int'(cmp_seq[1]), 5);
    chk("R9", "pending at cmp", int'(pending), 1);
    next_cycle(); settle();
    chk("R5", "cmp gone", int'(cmp_v), 0);
    chk("R9", "pending drained", int'(pending), 0);
  endtask

  task automatic t_squash_busy();
    do_reset();
    next_cycle();
    put(0, 1, 1, 0); put(1, 4, 0, 0); put(2, 6, 0, 0);
    settle();
    chk("R2", "squash takes no slot", int'(grant), 4'b0110);
    chk("R2", "squash popped", int'(pop), 4'b0111);
    next_cycle(); clr();
    put(0, 9, 0, 0); put(2, 2, 0, 0);
    settle();
    chk("R3", "busy class skipped", int'(grant), 4'b0001);
    chk("R3", "busy head kept", int'(pop), 4'b0001);
    next_cycle(); hd_valid[0] = 1'b0; settle();
    chk("R6", "still busy t+2", int'(grant), 0);
    chk("R5", "class1 done", int'(cmp_v), 4'b0010);
    next_cycle(); settle();
    chk("R6", "busy at completion", int'(grant), 0);
    chk("R6", "cmp class2", int'(cmp_v), 4'b0100);
    chk("R6", "cmp class2 seq", int'(cmp_seq[2]), 6);
    next_cycle(); settle();
    chk("R6", "freed at t+LAT", int'(grant), 4'b0100);
    next_cycle(); clr();
  endtask

  task automatic t_mem();
    do_reset();
    next_cycle();
    put(0, 4, 0, 0); put(1, 3, 0, 1);
    settle();
    chk("R7", "grant", int'(grant), 4'b0011);
    chk("R7", "release nonmem", int'(rel), 4'b0001);
    chk("R7", "memdep", int'(memdep), 4'b0010);
    next_cycle(); clr();
  endtask

  task automatic t_pipe();
    do_reset();
    next_cycle(); put(1, 20, 0, 0); settle();
    chk("R4", "first pipelined grant", int'(grant), 4'b0010);
    chk("R4", "no exec for multi", int'(exec_o), 0);
    next_cycle(); put(1, 21, 0, 0); settle();
    chk("R4", "back-to-back grant", int'(grant), 4'b0010);
    next_cycle(); clr(); settle();
    chk("R5", "cmp first", int'(cmp_seq[1]), 20);
    chk("R9", "two in flight", int'(pending), 2);
    next_cycle(); settle();
    chk("R5", "cmp second", int'(cmp_seq[1]), 21);
    chk("R5", "cmp second valid", int'(cmp_v), 4'b0010);
    next_cycle(); settle();
    chk("R9", "pending zero", int'(pending), 0);
  endtask

  task automatic t_simul();
    do_reset();
    next_cycle(); put(2, 30, 0, 0); settle();
    chk("R10", "class2 grant", int'(grant), 4'b0100);
    next_cycle(); clr(); put(1, 31, 0, 0); settle();
    next_cycle(); clr(); settle();
    next_cycle(); settle();
    chk("R10", "both complete", int'(cmp_v), 4'b0110);
    chk("R10", "class1 seq", int'(cmp_seq[1]), 31);
    chk("R10", "class2 seq", int'(cmp_seq[2]), 30);
  endtask

  initial begin
    clr();
    t_reset();
    t_width_age();
    t_squash_busy();
    t_mem();
    t_pipe();
    t_simul();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule